// File: doc/BRIEF.md
# Variable-Length Instruction Sequencer

This block is the multicycle control core of a small 16-bit machine with eight general registers. It reads an opcode word through a word-addressed single-port memory interface. It then reads the zero to three operand words that opcode calls for, executes the instruction and goes on to the next one. The instruction set covers register moves, conditional and unconditional branches, a push/pop stack, subroutine call and return, memory loads and stores, and character transfer in both directions. Arithmetic and logic results come from a separate combinational unit inside the block.

An operand word below 32768 is a literal. The codes 32768 to 32775 name registers 0 to 7. Any larger word is a fault. Character output and input each use a valid/ready pair, and the core waits on them for as long as needed. The core ends in one of two terminal conditions: `halted` for a normal stop, or `error` for a fault. Only a reset leaves either condition.

Top module: `seq_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0, clears all eight registers and empties the stack. It also drops `halted` and `error`.
- R2: Each instruction takes 1 + n words, where n is its operand count. Opcodes 0, 18 and 21 have n=0. Opcodes 2, 3, 6, 17, 19 and 20 have n=1. Opcodes 1, 7, 8, 14, 15 and 16 have n=2. Opcodes 4, 5, 9 to 13 have n=3. The next opcode is fetched from the word after the last operand, and `pc` shows that address.
- R3: An operand word below 32768 is a literal. The values 32768+k (k = 0..7) read register k. A word of 32776 or more sets `error`. A destination operand that is not a register code also sets `error`. The instructions with a destination are opcodes 1, 3, 4, 5, 9 to 15 and 20.
- R4: Opcode 1 copies B into A. Opcodes 4 and 5 write 1 or 0 to A: 4 tests B==C and 5 tests B>C. Opcode 9 writes (B+C) mod 32768 and opcode 10 writes (B*C) mod 32768. Opcode 11 writes B mod C and sets `error` when C is 0. Opcodes 12 and 13 write the bitwise AND and OR. Opcode 14 writes the 15-bit inverse of B.
- R5: Opcode 6 jumps to A. Opcode 7 jumps to B when A is nonzero. Opcode 8 jumps to B when A is zero. When a conditional branch is not taken, execution falls through.
- R6: Opcode 2 pushes A and opcode 3 pops into A, in last-in first-out order. A pop from an empty stack sets `error`. The stack holds 64 entries, and a push onto a full stack sets `error`.
- R7: Opcode 17 pushes the address of the following instruction and jumps to A. Opcode 18 pops an address and jumps to it. Opcode 18 on an empty stack sets `halted`, not `error`.
- R8: Opcode 15 loads the full 16-bit word at address B into A. Opcode 16 stores B at address A.
- R9: Opcode 19 holds `out_valid` with `out_data` equal to the low byte of A, and keeps `pc` stable, until `out_ready` is seen.
- R10: Opcode 20 holds `in_ready` until `in_valid` is seen. It then writes `in_data` into A, zero-extended.
- R11: Opcode 0 sets `halted`. `halted` and `error` never occur together. Each one stays until reset. While either is set, no memory access, character output or input request occurs.
- R12: An opcode word above 21 sets `error`.
- R13: `mem_rd` and `mem_we` are never asserted in the same cycle. Read data is taken one cycle after `mem_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Word address of the current memory access |
| mem_rd | output | 1 | Read request; data is expected on mem_rdata one cycle later |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data |
| out_valid | output | 1 | Output character is offered |
| out_data | output | 8 | Output character code |
| out_ready | input | 1 | Consumer accepts the character |
| in_valid | input | 1 | Input character is present |
| in_data | input | 8 | Input character code |
| in_ready | output | 1 | Core is waiting for an input character |
| pc | output | 16 | Program counter (next word to fetch) |
| halted | output | 1 | Normal stop |
| error | output | 1 | Fault stop |

## Verification
The assertions check these properties on every cycle:
- the output handshake holds its data and `pc` while it stalls;
- the input request persists until a character arrives;
- the two stop conditions are exclusive and sticky, and the core is silent once stopped;
- a read and a write never coincide;
- reset lands at address 0.

The arithmetic results, operand decoding, the instruction lengths, branch targets, stack order, the 64-entry boundary and the distinction between empty-stack pop and return can only be shown by running programs. The bench does this and compares stored words and emitted characters against its own model.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int DW      = 16;
    localparam int NREG    = 8;
    localparam int REG_AW  = $clog2(NREG);
    localparam int NOPND   = 3;

    localparam logic [DW-1:0] OP_LAST  = 16'd21;
    localparam logic [DW-1:0] REG_LAST = 16'h8007;

    typedef enum logic [4:0] {
        OP_HALT = 5'd0,  OP_SET  = 5'd1,  OP_PUSH = 5'd2,  OP_POP  = 5'd3,
        OP_EQ   = 5'd4,  OP_GT   = 5'd5,  OP_JMP  = 5'd6,  OP_JT   = 5'd7,
        OP_JF   = 5'd8,  OP_ADD  = 5'd9,  OP_MULT = 5'd10, OP_MOD  = 5'd11,
        OP_AND  = 5'd12, OP_OR   = 5'd13, OP_NOT  = 5'd14, OP_RMEM = 5'd15,
        OP_WMEM = 5'd16, OP_CALL = 5'd17, OP_RET  = 5'd18, OP_OUT  = 5'd19,
        OP_IN   = 5'd20, OP_NOOP = 5'd21
    } op_e;

    typedef enum logic [3:0] {
        S_FETCH, S_OPC, S_AREQ, S_ACAP, S_EXEC,
        S_RMEM, S_OUT, S_IN, S_HALT, S_ERR
    } state_e;

    typedef struct packed {
        op_e           op;
        logic [DW-1:0] b;
        logic [DW-1:0] c;
    } alu_req_t;

    typedef struct packed {
        logic [DW-1:0] y;
        logic          fault;
    } alu_rsp_t;

    function automatic logic [1:0] arg_count(input op_e op);
        case (op)
            OP_HALT, OP_RET, OP_NOOP:                          return 2'd0;
            OP_PUSH, OP_POP, OP_JMP, OP_CALL, OP_OUT, OP_IN:   return 2'd1;
            OP_SET, OP_JT, OP_JF, OP_NOT, OP_RMEM, OP_WMEM:    return 2'd2;
            default:                                           return 2'd3;
        endcase
    endfunction

    function automatic logic writes_dest(input op_e op);
        case (op)
            OP_SET, OP_POP, OP_EQ, OP_GT, OP_ADD, OP_MULT, OP_MOD,
            OP_AND, OP_OR, OP_NOT, OP_RMEM, OP_IN: return 1'b1;
            default:                               return 1'b0;
        endcase
    endfunction

    function automatic logic is_reg(input logic [DW-1:0] w);
        return w[DW-1] && (w[DW-2:REG_AW] == '0);
    endfunction
endpackage

// File: rtl/seq_alu.sv
module seq_alu
    import seq_pkg::*;
(
    input  alu_req_t req,
    output alu_rsp_t rsp
);
    logic [DW-1:0]   sum;
    logic [2*DW-1:0] prod;

    always_comb begin
        sum  = req.b + req.c;
        prod = (2*DW)'(req.b) * (2*DW)'(req.c);
        rsp  = '0;
        case (req.op)
            OP_EQ:   rsp.y = {{(DW-1){1'b0}}, req.b == req.c};
            OP_GT:   rsp.y = {{(DW-1){1'b0}}, req.b > req.c};
            OP_ADD:  rsp.y = {1'b0, sum[DW-2:0]};
            OP_MULT: rsp.y = {1'b0, prod[DW-2:0]};
            OP_MOD: begin
                if (req.c == '0) rsp.fault = 1'b1;
                else             rsp.y     = req.b % req.c;
            end
            OP_AND:  rsp.y = req.b & req.c;
            OP_OR:   rsp.y = req.b | req.c;
            OP_NOT:  rsp.y = {1'b0, ~req.b[DW-2:0]};
            default: rsp.y = '0;
        endcase
    end
endmodule

// File: rtl/seq_regs.sv
module seq_regs
    import seq_pkg::*;
#(
    parameter int N   = NREG,
    parameter int W   = DW,
    parameter int NRD = NOPND,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr [NRD],
    output logic [W-1:0]  rdata [NRD]
);
    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = regs[raddr[g]];
    end
endmodule

// File: rtl/seq_stack.sv
module seq_stack #(
    parameter int DEPTH = 64,
    parameter int W     = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top,
    output logic         empty,
    output logic         full
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [W-1:0]  slots [DEPTH];
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] top_idx;

    assign top_idx = AW'(cnt_q - ONE);
    assign top     = slots[top_idx];
    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (push && !full) begin
            slots[cnt_q[AW-1:0]] <= push_data;
            cnt_q <= cnt_q + ONE;
        end else if (pop && !empty) begin
            cnt_q <= cnt_q - ONE;
        end
    end
endmodule

// File: rtl/seq_core.sv
module seq_core
    import seq_pkg::*;
#(
    parameter int STACK_DEPTH = 64
) (
    input  logic          clk,
    input  logic          rst,
    output logic [DW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          out_valid,
    output logic [7:0]    out_data,
    input  logic          out_ready,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    output logic          in_ready,
    output logic [DW-1:0] pc,
    output logic          halted,
    output logic          error
);
    state_e        state_q;
    logic [DW-1:0] pc_q;
    op_e           opc_q;
    logic [1:0]    aidx_q;
    logic [1:0]    nargs_q;
    logic [DW-1:0] raw_q [NOPND];

    logic [REG_AW-1:0] rd_addr [NOPND];
    logic [DW-1:0]     rd_data [NOPND];
    logic [DW-1:0]     val     [NOPND];

    logic          rf_we_c, rf_we;
    logic [DW-1:0] rf_wd;
    logic          st_push, st_pop, st_empty, st_full;
    logic [DW-1:0] st_pd, st_top;
    logic          fault, do_halt, jump;
    logic [DW-1:0] jtarget;
    alu_req_t      alu_req;
    alu_rsp_t      alu_rsp;
    op_e           fetched_op;

    for (genvar g = 0; g < NOPND; g++) begin : g_opnd
        assign rd_addr[g] = raw_q[g][REG_AW-1:0];
        assign val[g]     = raw_q[g][DW-1] ? rd_data[g] : raw_q[g];

        always_ff @(posedge clk) begin
            if (rst)                                          raw_q[g] <= '0;
            else if (state_q == S_ACAP && aidx_q == 2'(g))    raw_q[g] <= mem_rdata;
        end
    end

    seq_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .waddr (raw_q[0][REG_AW-1:0]),
        .wdata (rf_wd),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    seq_stack #(.DEPTH(STACK_DEPTH), .W(DW)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (st_push),
        .pop       (st_pop),
        .push_data (st_pd),
        .top       (st_top),
        .empty     (st_empty),
        .full      (st_full)
    );

    assign alu_req.op = opc_q;
    assign alu_req.b  = val[1];
    assign alu_req.c  = val[2];

    seq_alu u_alu (
        .req (alu_req),
        .rsp (alu_rsp)
    );

    assign fetched_op = op_e'(mem_rdata[4:0]);
    assign rf_we      = rf_we_c && !fault;
    assign out_data   = val[0][7:0];
    assign pc         = pc_q;
    assign halted     = (state_q == S_HALT);
    assign error      = (state_q == S_ERR);

    always_comb begin
        mem_addr  = pc_q;
        mem_rd    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = val[1];
        out_valid = 1'b0;
        in_ready  = 1'b0;
        rf_we_c   = 1'b0;
        rf_wd     = alu_rsp.y;
        st_push   = 1'b0;
        st_pop    = 1'b0;
        st_pd     = val[0];
        fault     = 1'b0;
        do_halt   = 1'b0;
        jump      = 1'b0;
        jtarget   = val[0];
        case (state_q)
            S_FETCH, S_AREQ: mem_rd = 1'b1;
            S_EXEC: begin
                if (writes_dest(opc_q) && !is_reg(raw_q[0])) begin
                    fault = 1'b1;
                end else begin
                    case (opc_q)
                        OP_HALT: do_halt = 1'b1;
                        OP_SET: begin rf_we_c = 1'b1; rf_wd = val[1]; end
                        OP_PUSH: begin
                            if (st_full) fault = 1'b1;
                            else         st_push = 1'b1;
                        end
                        OP_POP: begin
                            if (st_empty) fault = 1'b1;
                            else begin
                                rf_we_c = 1'b1;
                                rf_wd   = st_top;
                                st_pop  = 1'b1;
                            end
                        end
                        OP_EQ, OP_GT, OP_ADD, OP_MULT, OP_MOD,
                        OP_AND, OP_OR, OP_NOT: begin
                            rf_we_c = 1'b1;
                            fault   = alu_rsp.fault;
                        end
                        OP_JMP: jump = 1'b1;
                        OP_JT: begin jump = (val[0] != '0); jtarget = val[1]; end
                        OP_JF: begin jump = (val[0] == '0); jtarget = val[1]; end
                        OP_RMEM: begin mem_rd = 1'b1; mem_addr = val[1]; end
                        OP_WMEM: begin mem_we = 1'b1; mem_addr = val[0]; end
                        OP_CALL: begin
                            if (st_full) fault = 1'b1;
                            else begin
                                st_push = 1'b1;
                                st_pd   = pc_q;
                                jump    = 1'b1;
                            end
                        end
                        OP_RET: begin
                            if (st_empty) do_halt = 1'b1;
                            else begin
                                st_pop  = 1'b1;
                                jump    = 1'b1;
                                jtarget = st_top;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            S_RMEM: begin rf_we_c = 1'b1; rf_wd = mem_rdata; end
            S_OUT:  out_valid = 1'b1;
            S_IN: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    rf_we_c = 1'b1;
                    rf_wd   = {8'd0, in_data};
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_FETCH;
            pc_q    <= '0;
            opc_q   <= OP_NOOP;
            aidx_q  <= '0;
            nargs_q <= '0;
        end else begin
            case (state_q)
                S_FETCH: begin
                    pc_q    <= pc_q + 16'd1;
                    state_q <= S_OPC;
                end
                S_OPC: begin
                    if (mem_rdata > OP_LAST) begin
                        state_q <= S_ERR;
                    end else begin
                        opc_q   <= fetched_op;
                        nargs_q <= arg_count(fetched_op);
                        aidx_q  <= '0;
                        state_q <= (arg_count(fetched_op) == 2'd0) ? S_EXEC : S_AREQ;
                    end
                end
                S_AREQ: begin
                    pc_q    <= pc_q + 16'd1;
                    state_q <= S_ACAP;
                end
                S_ACAP: begin
                    if (mem_rdata > REG_LAST)           state_q <= S_ERR;
                    else if (aidx_q == nargs_q - 2'd1)  state_q <= S_EXEC;
                    else begin
                        aidx_q  <= aidx_q + 2'd1;
                        state_q <= S_AREQ;
                    end
                end
                S_EXEC: begin
                    if (fault)        state_q <= S_ERR;
                    else if (do_halt) state_q <= S_HALT;
                    else begin
                        if (jump) pc_q <= jtarget;
                        case (opc_q)
                            OP_RMEM: state_q <= S_RMEM;
                            OP_OUT:  state_q <= S_OUT;
                            OP_IN:   state_q <= S_IN;
                            default: state_q <= S_FETCH;
                        endcase
                    end
                end
                S_RMEM: state_q <= S_FETCH;
                S_OUT:  if (out_ready) state_q <= S_FETCH;
                S_IN:   if (in_valid)  state_q <= S_FETCH;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/seq_core_chk.sv
module seq_core_chk (
    input logic        clk,
    input logic        rst,
    input logic        mem_rd,
    input logic        mem_we,
    input logic        out_valid,
    input logic        out_ready,
    input logic [7:0]  out_data,
    input logic        in_valid,
    input logic        in_ready,
    input logic [15:0] pc,
    input logic        halted,
    input logic        error
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (pc == 16'd0 && !halted && !error));

    p_out_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(pc)));

    p_in_wait_r10: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> in_ready);

    p_stop_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(halted && error));

    p_halt_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        error |=> error);

    p_stop_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (halted || error) |-> (!mem_rd && !mem_we && !out_valid && !in_ready));

    p_mem_excl_r13: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_we));
endmodule

bind seq_core seq_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_rd    (mem_rd),
    .mem_we    (mem_we),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .pc        (pc),
    .halted    (halted),
    .error     (error)
);

// File: tb/tb_seq_core.sv
`timescale 1ns/1ps
module tb_seq_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr, mem_wdata, pc;
    logic [15:0] mem_rdata = '0;
    logic        mem_rd, mem_we, out_valid, in_ready, halted, error;
    logic [7:0]  out_data;
    logic        out_ready = 1'b0;
    logic        in_valid  = 1'b0;
    logic [7:0]  in_data   = '0;

    always #2 clk = ~clk;

    seq_core dut (
        .clk(clk), .rst(rst),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .pc(pc), .halted(halted), .error(error)
    );

    logic [15:0] mem [0:1023];
    logic        tb_we = 1'b0;
    logic [9:0]  tb_wa = '0;
    logic [15:0] tb_wd = '0;

    always @(posedge clk) begin
        if (tb_we)       mem[tb_wa] <= tb_wd;
        else if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
    end

    logic [7:0] outq [$];
    logic       hold_out = 1'b0;
    int         in_avail = 0;
    logic [7:0] in_char  = '0;
    logic       in_fire  = 1'b0;

    always @(negedge clk) begin
        out_ready = hold_out ? 1'b0 : ($urandom % 4 != 0);
        if (out_valid && out_ready) outq.push_back(out_data);
        if (in_fire) in_valid = 1'b0;
        if (!in_valid && in_avail > 0 && ($urandom % 2 == 0)) begin
            in_valid = 1'b1;
            in_data  = in_char;
            in_avail--;
        end
        in_fire = in_valid && in_ready;
    end

    int n_chk = 0;
    int n_bad = 0;
    int wp    = 0;

    function automatic logic [15:0] R(input int k);
        return 16'h8000 + 16'(k);
    endfunction

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic put(input int a, input logic [15:0] w);
        @(negedge clk);
        tb_we = 1'b1;
        tb_wa = 10'(a);
        tb_wd = w;
    endtask

    task automatic emit(input logic [15:0] w);
        put(wp, w);
        wp++;
    endtask

    task automatic begin_prog();
        rst = 1'b1;
        wp  = 0;
        outq.delete();
    endtask

    task automatic run(input int limit);
        int n = 0;
        @(negedge clk);
        tb_we = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        while (!(halted || error) && n < limit) begin
            @(negedge clk);
            n++;
        end
        if (n >= limit) check_eq("R11", "program did not stop", 0, 1);
    endtask

    function automatic logic [31:0] packq();
        logic [31:0] v = '0;
        foreach (outq[i]) v = {v[23:0], outq[i]};
        return v;
    endfunction

    // Expected ALU results written from R4
    function automatic logic [15:0] alu_ref(input int op, input logic [15:0] b, input logic [15:0] c);
        case (op)
            4:  return (b == c) ? 16'd1 : 16'd0;
            5:  return (b > c) ? 16'd1 : 16'd0;
            9:  return 16'((32'(b) + 32'(c)) % 32768);
            10: return 16'((32'(b) * 32'(c)) % 32768);
            11: return b % c;
            12: return b & c;
            13: return b | c;
            default: return (~b) & 16'h7FFF;
        endcase
    endfunction

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int ops [8] = '{4, 5, 9, 10, 11, 12, 13, 14};
        logic [15:0] ex [6];
        int fix, fix2, loop_at;
        void'($urandom(32'h5EED));

        // R1: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_eq("R1", "pc after reset", pc, 0);
        check_eq("R1", "halted/error after reset", {halted, error}, 0);
        check_eq("R1", "no output/input/write in reset", {out_valid, in_ready, mem_we}, 0);

        // R4 R3: constrained random ALU programs, results stored with opcode 16
        for (int p = 0; p < 6; p++) begin
            begin_prog();
            for (int k = 0; k < 6; k++) begin
                int op;
                logic [15:0] b, c;
                bit rb, rc;
                op = ops[$urandom % 8];
                b  = 16'($urandom % 32768);
                c  = 16'($urandom % 32768);
                if ($urandom % 4 == 0) c = b;
                if (op == 11 && c == 0) c = 16'd1;
                rb = ($urandom % 2 == 0);
                rc = ($urandom % 2 == 0);
                ex[k] = alu_ref(op, b, c);
                emit(16'd1); emit(R(1)); emit(b);
                emit(16'd1); emit(R(2)); emit(c);
                emit(16'(op)); emit(R(3)); emit(rb ? R(1) : b);
                if (op != 14) emit(rc ? R(2) : c);
                emit(16'd16); emit(16'(900 + k)); emit(R(3));
            end
            emit(16'd0);
            run(4000);
            check_eq("R11", "random program halts", {halted, error}, 2'b10);
            for (int k = 0; k < 6; k++) check_eq("R4", "alu result", mem[900 + k], ex[k]);
        end

        // R1: registers cleared by reset (r1 was set by earlier programs)
        begin_prog();
        emit(16'd19); emit(R(1)); emit(16'd0);
        run(2000);
        check_eq("R1", "register zero after reset", packq(), 32'h00);

        // R2 R11: character output and halt address
        begin_prog();
        emit(16'd19); emit(16'h48);
        emit(16'd19); emit(16'h69);
        emit(16'd0);
        run(2000);
        check_eq("R9", "chars emitted", packq(), 32'h4869);
        check_eq("R2", "pc after halt", pc, 5);
        repeat (3) @(negedge clk);
        check_eq("R11", "halt sticky and quiet", {halted, error, mem_rd, mem_we}, 4'b1000);

        // R9: output stall holds data
        begin_prog();
        emit(16'd19); emit(16'h51);
        emit(16'd0);
        hold_out = 1'b1;
        fork
            run(2000);
            begin
                do @(negedge clk); while (!out_valid);
                repeat (5) @(negedge clk);
                check_eq("R9", "stalled out valid/data", {out_valid, out_data}, {1'b1, 8'h51});
                check_eq("R2", "pc during out stall", pc, 2);
                hold_out = 1'b0;
            end
        join
        check_eq("R9", "stalled char delivered once", packq(), 32'h51);

        // R5: branches
        begin_prog();
        emit(16'd1); emit(R(0)); emit(16'd5);
        emit(16'd7); emit(R(0)); fix = wp; emit(16'd0);
        emit(16'd19); emit(16'h58);
        put(fix, 16'(wp));
        emit(16'd8); emit(R(0)); emit(16'd0);
        emit(16'd19); emit(16'h59);
        emit(16'd7); emit(16'd0); emit(16'd0);
        emit(16'd8); emit(16'd0); fix2 = wp; emit(16'd0);
        emit(16'd19); emit(16'h5A);
        put(fix2, 16'(wp));
        emit(16'd19); emit(16'h4B);
        emit(16'd0);
        run(2000);
        check_eq("R5", "branch path chars", packq(), 32'h594B);

        // R6: stack order
        begin_prog();
        emit(16'd2); emit(16'd65);
        emit(16'd2); emit(16'd66);
        emit(16'd3); emit(R(0));
        emit(16'd3); emit(R(1));
        emit(16'd19); emit(R(0));
        emit(16'd19); emit(R(1));
        emit(16'd0);
        run(2000);
        check_eq("R6", "LIFO order", packq(), 32'h4241);

        // R6: pop from empty stack is a fault
        begin_prog();
        emit(16'd3); emit(R(0));
        emit(16'd0);
        run(2000);
        check_eq("R6", "empty pop", {halted, error}, 2'b01);

        // R6: 64-entry boundary
        begin_prog();
        emit(16'd1); emit(R(0)); emit(16'd0);
        loop_at = wp;
        emit(16'd2); emit(R(0));
        emit(16'd9); emit(R(0)); emit(R(0)); emit(16'd1);
        emit(16'd4); emit(R(1)); emit(R(0)); emit(16'd64);
        emit(16'd8); emit(R(1)); emit(16'(loop_at));
        emit(16'd3); emit(R(2));
        emit(16'd19); emit(R(2));
        emit(16'd2); emit(16'd7);
        emit(16'd2); emit(16'd7);
        emit(16'd0);
        run(20000);
        check_eq("R6", "top after 64 pushes", packq(), 32'h3F);
        check_eq("R6", "push when full", {halted, error}, 2'b01);

        // R7: call and return
        begin_prog();
        emit(16'd17); emit(16'd5);
        emit(16'd19); emit(16'h43);
        emit(16'd0);
        emit(16'd19); emit(16'h53);
        emit(16'd18);
        run(2000);
        check_eq("R7", "call/return chars", packq(), 32'h5343);
        check_eq("R7", "stop after call test", {halted, error}, 2'b10);

        // R7: return on empty stack halts
        begin_prog();
        emit(16'd18);
        emit(16'd0);
        run(2000);
        check_eq("R7", "empty return halts", {halted, error}, 2'b10);
        check_eq("R2", "pc after empty return", pc, 1);

        // R3: operand above register range
        begin_prog();
        emit(16'd1); emit(R(0)); emit(16'h8008);
        emit(16'd0);
        run(2000);
        check_eq("R3", "operand 32776", {halted, error}, 2'b01);

        // R3: literal destination
        begin_prog();
        emit(16'd1); emit(16'd5); emit(16'd7);
        emit(16'd0);
        run(2000);
        check_eq("R3", "literal destination", {halted, error}, 2'b01);

        // R12: undefined opcode
        begin_prog();
        emit(16'd22);
        emit(16'd0);
        run(2000);
        check_eq("R12", "opcode 22", {halted, error}, 2'b01);

        // R4: modulo by zero
        begin_prog();
        emit(16'd11); emit(R(0)); emit(16'd9); emit(16'd0);
        emit(16'd0);
        run(2000);
        check_eq("R4", "mod by zero", {halted, error}, 2'b01);

        // R8: load and store
        put(802, 16'hABCD);
        begin_prog();
        emit(16'd16); emit(16'd800); emit(16'd1234);
        emit(16'd15); emit(R(3)); emit(16'd800);
        emit(16'd16); emit(16'd801); emit(R(3));
        emit(16'd15); emit(R(4)); emit(16'd802);
        emit(16'd16); emit(16'd803); emit(R(4));
        emit(16'd19); emit(R(3));
        emit(16'd0);
        run(2000);
        check_eq("R8", "store literal / reload", mem[801], 16'd1234);
        check_eq("R8", "full 16-bit load", mem[803], 16'hABCD);
        check_eq("R9", "low byte out", packq(), 32'hD2);

        // R10: character input
        begin_prog();
        emit(16'd20); emit(R(5));
        emit(16'd19); emit(R(5));
        emit(16'd9); emit(R(6)); emit(R(5)); emit(16'd1);
        emit(16'd19); emit(R(6));
        emit(16'd0);
        fork
            run(2000);
            begin
                do @(negedge clk); while (!in_ready);
                repeat (4) @(negedge clk);
                check_eq("R10", "in_ready held while waiting", in_ready, 1);
                in_char  = 8'h61;
                in_avail = 1;
            end
        join
        check_eq("R10", "input echoed", packq(), 32'h6162);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule